// File: doc/BRIEF.md
# Restricted Four-Slot Rename Steering

This block sits at the front of a rename stage. Each cycle it sees a group of up to four decoded micro-ops in program order. It picks how many of them enter rename this cycle and places them into four output slots. Slots 0 to 2 take any kind of micro-op. The last slot is narrow: it takes only a direct branch, a NOP, or a move of immediate zero. Valid micro-ops are compacted toward slot 0 in program order. If all four lanes are valid and the fourth one cannot use the narrow slot, only three are taken. The fourth stays with the decoder, which presents it again in the next group.

The block also tags a move of immediate zero as a zeroing idiom, so rename can write the destination without using an execution unit. No other idiom is recognised. A register-to-register move is passed on as an ordinary micro-op. An XOR or subtract of a register with itself is also passed on as an ordinary micro-op.

The four output slots are registered. They load only while rename is ready. The number of micro-ops taken is reported in the same cycle, so the decoder can shift its queue.

Top module: `rn_steer_top`

## Requirements
- R1: When all four lanes are valid and lane 3 is eligible for the narrow slot, four micro-ops are taken (take_cnt_o = 4). After the next clock edge all four output slots are valid.
- R2: Output slot 3 holds only a direct branch (class 6), a NOP (class 9) or an immediate move (class 10) whose 16-bit immediate is zero. If lane 3 is any other class, take_cnt_o is 3 and slot 3 is invalid.
- R3: A compare-and-branch (class 7) never occupies slot 3. An indirect branch (class 8) never occupies slot 3 either.
- R4: An immediate move with immediate zero sets rn_zero_o for its slot, in any slot. An immediate move with a nonzero immediate does not set the flag and is not eligible for slot 3.
- R5: A register move (class 11) is not eliminated. It is forwarded unchanged, with rn_zero_o clear, and it is not eligible for slot 3.
- R6: An XOR (class 2) or subtract (class 1) whose sources name the same register is not a zeroing idiom. Its rn_zero_o is clear and it is not eligible for slot 3.
- R7: The micro-ops that are taken appear in the output slots in lane order, and each one's fields are unchanged.
- R8: Valid lanes are packed from slot 0 upward with no gaps, whatever the lane valid pattern. take_cnt_o equals the number of valid lanes whenever fewer than four lanes are valid.
- R9: While rn_rdy_i is low, take_cnt_o and dec_rdy_o are 0, and rn_vld_o, rn_uop_o and rn_zero_o keep their values.
- R10: During reset and right after it, all output slots are invalid and rn_zero_o is 0.
- R11: While rn_rdy_i is high, the number of valid output slots after the clock edge equals take_cnt_o before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_vld_i | input | 4 | Per-lane valid; lane 0 is oldest |
| dec_uop_i | input | 4*35 | Lane micro-ops, lane i at bits [i*35 +: 35]; each is {class[3:0], dst[4:0], src1[4:0], src2[4:0], imm[15:0]} MSB first |
| dec_rdy_o | output | 1 | Block accepts this cycle |
| take_cnt_o | output | 3 | Number of lanes consumed this cycle |
| rn_rdy_i | input | 1 | Rename stage ready |
| rn_vld_o | output | 4 | Per-slot valid to rename |
| rn_uop_o | output | 4*35 | Slot micro-ops, same layout as input |
| rn_zero_o | output | 4 | Per-slot zeroing-idiom flag |

## Verification
The hardest case to reach from the ports is a partially taken group. It needs all four lanes valid together with an ineligible micro-op in lane 3. It also needs a follow-up cycle where the decoder re-presents the leftover micro-op alone in lane 0. The bench builds this directly, using several kinds of ineligible micro-op: compare-and-branch, indirect branch, nonzero immediate move, register move, self-XOR and FP. It then re-presents the leftover and checks that it comes out in slot 0. The bench also checks that outputs hold when rename stops being ready, and it uses sparse lane-valid patterns to check the packing.

// File: rtl/rn_steer_pkg.sv
package rn_steer_pkg;
  localparam int CLS_W = 4;
  localparam int REG_W = 5;
  localparam int IMM_W = 16;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD    = 4'd0,
    CLS_SUB    = 4'd1,
    CLS_XOR    = 4'd2,
    CLS_MUL    = 4'd3,
    CLS_LOAD   = 4'd4,
    CLS_STORE  = 4'd5,
    CLS_BR_DIR = 4'd6,
    CLS_BR_CZ  = 4'd7,
    CLS_BR_IND = 4'd8,
    CLS_NOP    = 4'd9,
    CLS_MOVI   = 4'd10,
    CLS_MOVR   = 4'd11,
    CLS_FP     = 4'd12
  } op_cls_e;

  typedef struct packed {
    op_cls_e          cls;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src1;
    logic [REG_W-1:0] src2;
    logic [IMM_W-1:0] imm;
  } uop_t;

  localparam int UOP_W = $bits(uop_t);
endpackage

// File: rtl/rn_uop_classify.sv
module rn_uop_classify
  import rn_steer_pkg::*;
(
  input  uop_t uop_i,
  output logic tail_ok_o,
  output logic zero_o
);
  logic imm_is_zero;

  assign imm_is_zero = (uop_i.imm == '0);
  // only an immediate-zero move counts; reg moves and self-xor/sub do not
  assign zero_o      = (uop_i.cls == CLS_MOVI) && imm_is_zero;
  assign tail_ok_o   = (uop_i.cls == CLS_BR_DIR) || (uop_i.cls == CLS_NOP) || zero_o;
endmodule

// File: rtl/rn_slot_pack.sv
module rn_slot_pack
  import rn_steer_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int IDX_W = $clog2(NSLOT)
) (
  input  logic [NSLOT-1:0]       vld_i,
  input  uop_t [NSLOT-1:0]       uop_i,
  input  logic [NSLOT-1:0]       tail_ok_i,
  input  logic [NSLOT-1:0]       zero_i,
  output logic [NSLOT-1:0]       vld_o,
  output uop_t [NSLOT-1:0]       uop_o,
  output logic [NSLOT-1:0]       zero_o,
  output logic [CNT_W-1:0]       cnt_o
);
  logic [CNT_W-1:0] pos;
  logic             tail_block;

  // a full group with an ineligible youngest op leaves that op behind
  assign tail_block = (&vld_i) && !tail_ok_i[NSLOT-1];

  always_comb begin
    vld_o  = '0;
    uop_o  = '0;
    zero_o = '0;
    pos    = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (vld_i[i]) begin
        vld_o[pos[IDX_W-1:0]]  = 1'b1;
        uop_o[pos[IDX_W-1:0]]  = uop_i[i];
        zero_o[pos[IDX_W-1:0]] = zero_i[i];
        pos = pos + 1'b1;
      end
    end
    cnt_o = pos;
    if (tail_block) begin
      vld_o[NSLOT-1]  = 1'b0;
      uop_o[NSLOT-1]  = '0;
      zero_o[NSLOT-1] = 1'b0;
      cnt_o           = CNT_W'(NSLOT - 1);
    end
  end

  // R8: fewer than NSLOT valid lanes are all taken
  always_comb begin
    if (!(&vld_i)) begin
      a_partial_all_r8: assert (cnt_o == CNT_W'($countones(vld_i)));
    end
  end
endmodule

// File: rtl/rn_steer_top.sv
module rn_steer_top
  import rn_steer_pkg::*;
#(
  parameter int NSLOT = 4,
  localparam int CNT_W = $clog2(NSLOT + 1),
  localparam int BUS_W = NSLOT * UOP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NSLOT-1:0] dec_vld_i,
  input  logic [BUS_W-1:0] dec_uop_i,
  output logic             dec_rdy_o,
  output logic [CNT_W-1:0] take_cnt_o,
  input  logic             rn_rdy_i,
  output logic [NSLOT-1:0] rn_vld_o,
  output logic [BUS_W-1:0] rn_uop_o,
  output logic [NSLOT-1:0] rn_zero_o
);
  uop_t [NSLOT-1:0] lane_uop;
  logic [NSLOT-1:0] lane_tail_ok;
  logic [NSLOT-1:0] lane_zero;
  logic [NSLOT-1:0] pk_vld;
  uop_t [NSLOT-1:0] pk_uop;
  logic [NSLOT-1:0] pk_zero;
  logic [CNT_W-1:0] pk_cnt;

  logic [NSLOT-1:0] vld_q;
  uop_t [NSLOT-1:0] uop_q;
  logic [NSLOT-1:0] zero_q;

  assign lane_uop = dec_uop_i;

  for (genvar g = 0; g < NSLOT; g++) begin : g_cls
    rn_uop_classify u_cls (
      .uop_i     (lane_uop[g]),
      .tail_ok_o (lane_tail_ok[g]),
      .zero_o    (lane_zero[g])
    );
  end

  rn_slot_pack #(.NSLOT(NSLOT)) u_pack (
    .vld_i     (dec_vld_i),
    .uop_i     (lane_uop),
    .tail_ok_i (lane_tail_ok),
    .zero_i    (lane_zero),
    .vld_o     (pk_vld),
    .uop_o     (pk_uop),
    .zero_o    (pk_zero),
    .cnt_o     (pk_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      uop_q  <= '0;
      zero_q <= '0;
    end else if (rn_rdy_i) begin
      vld_q  <= pk_vld;
      uop_q  <= pk_uop;
      zero_q <= pk_zero;
    end
  end

  assign dec_rdy_o  = rn_rdy_i;
  assign take_cnt_o = rn_rdy_i ? pk_cnt : '0;
  assign rn_vld_o   = vld_q;
  assign rn_uop_o   = uop_q;
  assign rn_zero_o  = zero_q;

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_cnt_o <= CNT_W'(NSLOT));

  p_tail_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rn_vld_o[NSLOT-1] |-> (uop_q[NSLOT-1].cls == CLS_BR_DIR || uop_q[NSLOT-1].cls == CLS_NOP ||
                           (uop_q[NSLOT-1].cls == CLS_MOVI && uop_q[NSLOT-1].imm == '0)));

  p_tail_no_cbz_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rn_vld_o[NSLOT-1] |-> (uop_q[NSLOT-1].cls != CLS_BR_CZ && uop_q[NSLOT-1].cls != CLS_BR_IND));

  for (genvar g = 0; g < NSLOT; g++) begin : g_chk
    p_zero_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rn_zero_o[g] |-> (rn_vld_o[g] && uop_q[g].cls == CLS_MOVI && uop_q[g].imm == '0));
    p_no_mov_elim_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rn_vld_o[g] && uop_q[g].cls == CLS_MOVR) |-> !rn_zero_o[g]);
    p_no_self_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rn_vld_o[g] && (uop_q[g].cls == CLS_XOR || uop_q[g].cls == CLS_SUB)) |-> !rn_zero_o[g]);
    if (g < NSLOT - 1) begin : g_pk
      p_no_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rn_vld_o[g+1] |-> rn_vld_o[g]);
    end
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rn_rdy_i |=> ($stable(rn_vld_o) && $stable(rn_uop_o) && $stable(rn_zero_o)));

  p_no_take_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rn_rdy_i |-> (take_cnt_o == '0));

  p_cnt_match_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rn_rdy_i |=> (CNT_W'($countones(rn_vld_o)) == $past(take_cnt_o)));
endmodule

// File: tb/rn_steer_top_tb_top.sv
`timescale 1ns/1ps
module rn_steer_top_tb_top;
  import rn_steer_pkg::*;

  localparam int N = 4;
  localparam int BW = N * UOP_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dec_vld = '0;
  logic [BW-1:0] dec_uop = '0;
  logic          dec_rdy;
  logic [2:0]    take_cnt;
  logic          rn_rdy = 1'b0;
  logic [N-1:0]  rn_vld;
  logic [BW-1:0] rn_uop;
  logic [N-1:0]  rn_zero;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rn_steer_top #(.NSLOT(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dec_vld_i(dec_vld), .dec_uop_i(dec_uop),
    .dec_rdy_o(dec_rdy), .take_cnt_o(take_cnt), .rn_rdy_i(rn_rdy),
    .rn_vld_o(rn_vld), .rn_uop_o(rn_uop), .rn_zero_o(rn_zero)
  );

  function automatic logic [UOP_W-1:0] mk(op_cls_e c, int d, int s1, int s2, int im);
    uop_t u;
    u.cls  = c;
    u.dst  = REG_W'(d);
    u.src1 = REG_W'(s1);
    u.src2 = REG_W'(s2);
    u.imm  = IMM_W'(im);
    return u;
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // called just after a negedge; sets inputs and checks the same-cycle count
  task automatic present(logic [N-1:0] v, logic [UOP_W-1:0] u0, u1, u2, u3, logic rdy,
                         int exp_take, string tag);
    dec_vld = v;
    dec_uop = {u3, u2, u1, u0};
    rn_rdy  = rdy;
    #1;
    chk({tag, " take"}, 64'(take_cnt), 64'(exp_take));
  endtask

  task automatic cyc();
    @(negedge clk);
    dec_vld = '0;
  endtask

  function automatic logic [UOP_W-1:0] slot(int k);
    return rn_uop[k*UOP_W +: UOP_W];
  endfunction

  task automatic t_reset();
    chk("R10 vld in reset", 64'(rn_vld), 0);
    chk("R10 zero in reset", 64'(rn_zero), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 vld after reset", 64'(rn_vld), 0);
  endtask

  task automatic t_full();
    logic [UOP_W-1:0] a, b, c, d;
    a = mk(CLS_ADD, 1, 2, 3, 0); b = mk(CLS_LOAD, 4, 5, 0, 8);
    c = mk(CLS_MUL, 6, 1, 4, 0); d = mk(CLS_BR_DIR, 0, 0, 0, 100);
    present(4'b1111, a, b, c, d, 1'b1, 4, "R1 full");
    cyc();
    chk("R11 full vld", 64'(rn_vld), 64'hf);
    chk("R7 slot0", 64'(slot(0)), 64'(a));
    chk("R7 slot1", 64'(slot(1)), 64'(b));
    chk("R7 slot2", 64'(slot(2)), 64'(c));
    chk("R1 slot3 br", 64'(slot(3)), 64'(d));
    d = mk(CLS_NOP, 0, 0, 0, 0);
    present(4'b1111, a, b, c, d, 1'b1, 4, "R2 nop tail");
    cyc();
    chk("R2 nop slot3", 64'(slot(3)), 64'(d));
  endtask

  task automatic t_reject();
    logic [UOP_W-1:0] a, f;
    a = mk(CLS_ADD, 1, 2, 3, 0); f = mk(CLS_FP, 9, 9, 8, 0);
    present(4'b1111, a, a, mk(CLS_SUB, 7, 1, 1, 0), f, 1'b1, 3, "R2 fp tail");
    cyc();
    chk("R2 fp tail vld", 64'(rn_vld), 64'h7);
    chk("R7 slot2 kept", 64'(slot(2)), 64'(mk(CLS_SUB, 7, 1, 1, 0)));
    present(4'b0001, f, '0, '0, '0, 1'b1, 1, "R2 leftover");
    cyc();
    chk("R2 leftover slot0", 64'(slot(0)), 64'(f));
    chk("R2 leftover vld", 64'(rn_vld), 64'h1);
    present(4'b1111, a, a, a, mk(CLS_BR_CZ, 0, 3, 0, 12), 1'b1, 3, "R3 cbz tail");
    cyc();
    chk("R3 cbz vld", 64'(rn_vld), 64'h7);
    present(4'b1111, a, a, a, mk(CLS_BR_IND, 0, 3, 0, 0), 1'b1, 3, "R3 ind tail");
    cyc();
  endtask

  task automatic t_zero();
    logic [UOP_W-1:0] a, z, nz;
    a = mk(CLS_ADD, 1, 2, 3, 0); z = mk(CLS_MOVI, 5, 0, 0, 0); nz = mk(CLS_MOVI, 5, 0, 0, 5);
    present(4'b1111, z, a, a, z, 1'b1, 4, "R4 zero tail");
    cyc();
    chk("R4 zero flags", 64'(rn_zero), 64'h9);
    present(4'b1111, nz, a, a, nz, 1'b1, 3, "R4 nonzero tail");
    cyc();
    chk("R4 nonzero flags", 64'(rn_zero), 0);
  endtask

  task automatic t_no_idiom();
    logic [UOP_W-1:0] mr, xs, ss;
    mr = mk(CLS_MOVR, 3, 4, 0, 0); xs = mk(CLS_XOR, 3, 3, 3, 0); ss = mk(CLS_SUB, 6, 6, 6, 0);
    present(4'b1111, xs, mr, ss, mr, 1'b1, 3, "R5 movr tail");
    cyc();
    chk("R5 movr passed", 64'(slot(1)), 64'(mr));
    chk("R6 no zero flags", 64'(rn_zero), 0);
    present(4'b1111, mr, mr, mr, xs, 1'b1, 3, "R6 xor tail");
    cyc();
    chk("R6 xor tail vld", 64'(rn_vld), 64'h7);
  endtask

  task automatic t_sparse();
    logic [UOP_W-1:0] p, q, f;
    p = mk(CLS_LOAD, 1, 2, 0, 4); q = mk(CLS_STORE, 0, 3, 4, 8); f = mk(CLS_FP, 2, 2, 2, 0);
    present(4'b1010, f, p, f, q, 1'b1, 2, "R8 sparse 1010");
    cyc();
    chk("R8 sparse vld", 64'(rn_vld), 64'h3);
    chk("R8 sparse slot0", 64'(slot(0)), 64'(p));
    chk("R8 sparse slot1", 64'(slot(1)), 64'(q));
    present(4'b1110, p, q, f, f, 1'b1, 3, "R8 three valid");
    cyc();
    chk("R8 three slot2", 64'(slot(2)), 64'(f));
    present(4'b0000, p, q, f, f, 1'b1, 0, "R8 empty");
    cyc();
    chk("R8 empty vld", 64'(rn_vld), 0);
  endtask

  task automatic t_stall();
    logic [UOP_W-1:0] a, z;
    a = mk(CLS_ADD, 8, 9, 10, 0); z = mk(CLS_MOVI, 11, 0, 0, 0);
    present(4'b1111, a, a, a, z, 1'b1, 4, "R9 preload");
    cyc();
    present(4'b0011, mk(CLS_FP, 1, 1, 1, 0), a, a, a, 1'b0, 0, "R9 stalled");
    chk("R9 dec_rdy low", 64'(dec_rdy), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R9 hold vld", 64'(rn_vld), 64'hf);
    chk("R9 hold slot3", 64'(slot(3)), 64'(z));
    chk("R9 hold zero", 64'(rn_zero), 64'h8);
    dec_vld = '0;
    rn_rdy = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_full();
    t_reject();
    t_zero();
    t_no_idiom();
    t_sparse();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule